// File: doc/BRIEF.md
# Converter Result and Status Flag Unit

This unit sits between an eight-channel analog-to-digital converter sequencer and the register read path of its controller. Each finished conversion arrives on a valid/ready stream that carries a channel number and a result. The unit stores the result in a holding register for that channel and also in a shared "most recent result" register. It keeps the flags that software polls: a conversion-done flag per channel, an overrun flag per channel, a new-result flag and a global overrun flag. It also passes two receive-buffer status levels from a DMA engine through to the status word.

Reading a register has side effects. A read of a channel register clears that channel's done flag. A read of the most-recent register clears every done flag and the new-result flag. A read of the status word clears the overrun flags. Read data is combinational in the cycle of the read and shows the state from before that read's clearing takes effect. The result stream never applies back-pressure: `res_ready` is held high, so every cycle in which `res_valid` is high is a transfer.

Top module: `adc_result_flags`

## Requirements
- R1: Address 0 reads the status word in the same cycle as the read. Bits 7:0 are the done flags, bits 15:8 are the overrun flags, bit 16 is new-result, bit 17 is global overrun, bit 18 is the receive-end level and bit 19 is the buffer-full level. Bits 31:20 read as 0. The value returned is the one from before that read clears anything.
- R2: While reset is active and right after it, the status word reads 0x000C0000 and every result register reads 0.
- R3: Done flag n sets on a transfer for channel n. It clears on a read of channel n's register or of the most-recent register. If a set and a clear happen in the same cycle, the set wins.
- R4: Overrun flag n sets when channel n delivers a result while its done flag is set and is not being cleared in that same cycle. It clears on a status read, and a set in the same cycle as that read wins.
- R5: New-result sets on any accepted transfer. It clears only on a read of the most-recent register, with a set in the same cycle winning. A read of a channel register leaves it unchanged.
- R6: Global overrun sets when a transfer is accepted while new-result is set and is not being cleared in that cycle. It stays set until a status read.
- R7: Bits 18 and 19 are not sticky. Each shows its DMA input level as sampled at the previous clock edge.
- R8: A transfer writes its result to channel register n (address 8+n) and to the most-recent register (address 1). Addresses 2 to 7 read as 0.
- R9: With IMPL_CH implemented channels, a transfer for channel IMPL_CH or above is ignored. It changes no flag and no register, and that channel's register and flags read as 0.
- R10: `res_ready` is always 1. A transfer happens in every cycle in which `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Always 1, no back-pressure |
| res_chan | input | 3 | Channel number of the result |
| res_data | input | DATA_W | Conversion result |
| dma_rx_end | input | 1 | DMA receive-end level |
| dma_rx_full | input | 1 | DMA receive-buffer-full level |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register address |
| rd_data | output | 32 | Read data, valid in the cycle of rd_en |

## Verification
Read data is combinational, so the bench drives a read at a falling edge and samples `rd_data` half a cycle later, before the rising edge that applies the clear. Every flag change caused by a transfer or by a read's clear shows up one rising edge later. The bench therefore checks each effect with a read in the following cycle. The DMA bits pass through one register, so the bench waits one idle edge after changing a DMA level before reading status. Same-cycle cases (a set together with a clearing read) put both stimuli in one cycle and check both the returned value and the state one cycle later.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
  localparam int NUM_CH    = 8;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int ADDR_W    = CH_W + 1;
  localparam int WORD_W    = 32;
  // status word bit positions (software decodes these)
  localparam int DONE_LSB  = 0;
  localparam int OVR_LSB   = 8;
  localparam int NEW_BIT   = 16;
  localparam int GOVR_BIT  = 17;
  localparam int RXEND_BIT = 18;
  localparam int RXFULL_BIT= 19;
  // register addresses
  localparam logic [ADDR_W-1:0] A_STATUS = '0;
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(1);
endpackage

// File: rtl/adc_chan_slot.sv
module adc_chan_slot #(
  parameter int  DATA_W = 10,
  parameter bit  PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [DATA_W-1:0] din,
  input  logic              clr_done,
  input  logic              clr_ovr,
  output logic              done,
  output logic              ovr,
  output logic [DATA_W-1:0] dout
);
  generate
    if (PRESENT) begin : g_live
      logic              done_q, ovr_q;
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          done_q <= 1'b0;
          ovr_q  <= 1'b0;
          data_q <= '0;
        end else begin
          done_q <= hit | (done_q & ~clr_done);
          ovr_q  <= (hit & done_q & ~clr_done) | (ovr_q & ~clr_ovr);
          if (hit) data_q <= din;
        end
      end
      assign done = done_q;
      assign ovr  = ovr_q;
      assign dout = data_q;

      assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> done);
      assert_done_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && clr_done) |=> !done);
      assert_ovr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && done && !clr_done) |=> ovr);
      assert_ovr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_ovr) |=> ovr);
      assert_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (dout == $past(din)));
    end else begin : g_absent
      assign done = 1'b0;
      assign ovr  = 1'b0;
      assign dout = '0;
    end
  endgenerate
endmodule

// File: rtl/adc_last_result.sv
module adc_last_result #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_hit,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_last,
  input  logic              rd_status,
  output logic              new_res,
  output logic              govr,
  output logic [DATA_W-1:0] dout
);
  logic              new_q, govr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q  <= 1'b0;
      govr_q <= 1'b0;
      data_q <= '0;
    end else begin
      new_q  <= any_hit | (new_q & ~rd_last);
      govr_q <= (any_hit & new_q & ~rd_last) | (govr_q & ~rd_status);
      if (any_hit) data_q <= din;
    end
  end

  assign new_res = new_q;
  assign govr    = govr_q;
  assign dout    = data_q;

  assert_new_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> new_res);
  assert_new_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (new_res && !rd_last) |=> new_res);
  assert_govr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && new_res && !rd_last) |=> govr);
  assert_govr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (govr && !rd_status) |=> govr);
endmodule

// File: rtl/adc_dma_level.sv
module adc_dma_level (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_end_in,
  input  logic rx_full_in,
  output logic rx_end,
  output logic rx_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_end  <= 1'b1;
      rx_full <= 1'b1;
    end else begin
      rx_end  <= rx_end_in;
      rx_full <= rx_full_in;
    end
  end

  assert_rxend_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_end == $past(rx_end_in)));
  assert_rxfull_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_full == $past(rx_full_in)));
endmodule

// File: rtl/adc_result_flags.sv
module adc_result_flags
  import adc_flag_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int IMPL_CH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 res_valid,
  output logic                 res_ready,
  input  logic [CH_W-1:0]      res_chan,
  input  logic [DATA_W-1:0]    res_data,
  input  logic                 dma_rx_end,
  input  logic                 dma_rx_full,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [WORD_W-1:0]    rd_data
);
  logic              chan_ok, any_hit;
  logic              rd_status, rd_last, rd_chan;
  logic [CH_W-1:0]   rd_idx;
  logic [NUM_CH-1:0] hit, clr_done, done, ovr;
  logic [DATA_W-1:0] ch_data [NUM_CH];
  logic [DATA_W-1:0] last_data;
  logic              new_res, govr, rx_end, rx_full;
  logic [WORD_W-1:0] status;

  assign res_ready = 1'b1;
  assign chan_ok   = int'(res_chan) < IMPL_CH;
  assign any_hit   = res_valid & chan_ok;

  assign rd_status = rd_en && (rd_addr == A_STATUS);
  assign rd_last   = rd_en && (rd_addr == A_LAST);
  assign rd_chan   = rd_en && rd_addr[ADDR_W-1];
  assign rd_idx    = rd_addr[CH_W-1:0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign hit[n]      = any_hit && (res_chan == CH_W'(n));
    assign clr_done[n] = rd_last || (rd_chan && (rd_idx == CH_W'(n)));
    adc_chan_slot #(.DATA_W(DATA_W), .PRESENT(n < IMPL_CH)) u_slot (
      .clk(clk), .rst_n(rst_n), .hit(hit[n]), .din(res_data),
      .clr_done(clr_done[n]), .clr_ovr(rd_status),
      .done(done[n]), .ovr(ovr[n]), .dout(ch_data[n])
    );
  end

  adc_last_result #(.DATA_W(DATA_W)) u_last (
    .clk(clk), .rst_n(rst_n), .any_hit(any_hit), .din(res_data),
    .rd_last(rd_last), .rd_status(rd_status),
    .new_res(new_res), .govr(govr), .dout(last_data)
  );

  adc_dma_level u_dma (
    .clk(clk), .rst_n(rst_n), .rx_end_in(dma_rx_end), .rx_full_in(dma_rx_full),
    .rx_end(rx_end), .rx_full(rx_full)
  );

  always_comb begin
    status = '0;
    status[DONE_LSB +: NUM_CH] = done;
    status[OVR_LSB  +: NUM_CH] = ovr;
    status[NEW_BIT]    = new_res;
    status[GOVR_BIT]   = govr;
    status[RXEND_BIT]  = rx_end;
    status[RXFULL_BIT] = rx_full;
  end

  always_comb begin
    rd_data = '0;
    if (rd_status)    rd_data = status;
    else if (rd_last) rd_data = WORD_W'(last_data);
    else if (rd_chan) rd_data = WORD_W'(ch_data[rd_idx]);
  end

  assert_status_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> (rd_data[WORD_W-1:RXFULL_BIT+1] == '0));
  assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  assert_bad_chan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !chan_ok) |=> $stable(last_data));
endmodule

// File: tb/tb_adc_result_flags.sv
module tb_adc_result_flags;
  localparam int DW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 1'b0, res_ready;
  logic [2:0] res_chan = '0;
  logic [DW-1:0] res_data = '0;
  logic dma_rx_end = 1'b0, dma_rx_full = 1'b0;
  logic rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;
  int n_chk = 0, n_bad = 0;
  logic [31:0] got;

  always #10 clk = ~clk;

  adc_result_flags #(.DATA_W(DW), .IMPL_CH(6)) dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .dma_rx_end(dma_rx_end),
    .dma_rx_full(dma_rx_full), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {op(0=transfer,1=read), chan/addr, data, expected read value}
  localparam int NV = 17;
  localparam logic [55:0] VEC [0:NV-1] = '{
    {4'd0, 4'd2,  16'h0155, 32'h0},          // transfer ch2
    {4'd1, 4'd0,  16'h0,    32'h00010004},   // R3 R5 done2 + new
    {4'd1, 4'd10, 16'h0,    32'h00000155},   // R8 ch2 register
    {4'd1, 4'd0,  16'h0,    32'h00010000},   // R5 channel read keeps new
    {4'd0, 4'd5,  16'h00AA, 32'h0},          // ch5 while new set
    {4'd1, 4'd0,  16'h0,    32'h00030020},   // R6 global overrun
    {4'd1, 4'd0,  16'h0,    32'h00010020},   // R6 cleared by status read
    {4'd0, 4'd5,  16'h03FF, 32'h0},          // ch5 again
    {4'd1, 4'd0,  16'h0,    32'h00032020},   // R4 overrun ch5
    {4'd1, 4'd1,  16'h0,    32'h000003FF},   // R8 most-recent register
    {4'd1, 4'd0,  16'h0,    32'h00000000},   // R3 R5 cleared by last read
    {4'd1, 4'd13, 16'h0,    32'h000003FF},   // R8 ch5 register
    {4'd0, 4'd7,  16'h0111, 32'h0},          // unimplemented ch7
    {4'd1, 4'd0,  16'h0,    32'h00000000},   // R9 no flags
    {4'd1, 4'd15, 16'h0,    32'h00000000},   // R9 ch7 reads 0
    {4'd1, 4'd1,  16'h0,    32'h000003FF},   // R9 most-recent untouched
    {4'd1, 4'd2,  16'h0,    32'h00000000}    // R8 unmapped address
  };
  localparam string VREQ [0:NV-1] = '{"R10","R3","R8","R5","R10","R6","R6","R10",
    "R4","R8","R3","R8","R9","R9","R9","R9","R8"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit tv, input logic [2:0] ch, input logic [DW-1:0] d,
                     input bit rv, input logic [3:0] a, output logic [31:0] r);
    @(negedge clk);
    res_valid = tv; res_chan = ch; res_data = d;
    rd_en = rv; rd_addr = a;
    #5 r = rd_data;
    @(posedge clk);
    #1 res_valid = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rd_en = 1'b1; rd_addr = 4'd0;
    #25 chk("R2", rd_data, 32'h000C0000);
    rd_addr = 4'd8;
    #2 chk("R2", rd_data, 32'h0);
    rd_addr = 4'd1;
    #2 chk("R2", rd_data, 32'h0);
    rd_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R2", rd_data | 32'h0, 32'h0);
    chk("R10", {31'h0, res_ready}, 32'h1);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R7", got, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][55:52] == 4'd0) begin
        cyc(1, VEC[i][50:48], VEC[i][32 +: DW], 0, 4'd0, got);
        chk("R10", {31'h0, res_ready}, 32'h1);
      end else begin
        cyc(0, 0, 0, 1, VEC[i][51:48], got);
        chk(VEC[i] == VEC[i] ? VREQ[i] : "", got, VEC[i][31:0]);
      end
    end

    // R3: set wins over channel read, old data returned, no overrun
    cyc(1, 3'd1, 10'h010, 0, 4'd0, got);
    cyc(1, 3'd1, 10'h020, 1, 4'd9, got);
    chk("R3", got, 32'h00000010);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R4", got, 32'h00030002);
    // R5/R6: transfer with last read: new stays, no global overrun
    cyc(1, 3'd0, 10'h0F0, 1, 4'd1, got);
    chk("R8", got, 32'h00000020);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R6", got, 32'h00010001);
    cyc(0, 0, 0, 1, 4'd9, got);
    chk("R8", got, 32'h00000020);
    // R7: DMA levels one edge later, not sticky
    @(negedge clk); dma_rx_end = 1'b1;
    cyc(0, 0, 0, 0, 4'd0, got);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R7", got, 32'h00050001);
    @(negedge clk); dma_rx_end = 1'b0; dma_rx_full = 1'b1;
    cyc(0, 0, 0, 0, 4'd0, got);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R7", got, 32'h00090001);
    @(negedge clk); dma_rx_full = 1'b0;
    cyc(0, 0, 0, 0, 4'd0, got);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R7", got, 32'h00010001);
    // R4: overrun set in same cycle as status read wins
    cyc(1, 3'd3, 10'h001, 0, 4'd0, got);
    cyc(1, 3'd3, 10'h002, 0, 4'd0, got);
    cyc(1, 3'd3, 10'h003, 1, 4'd0, got);
    chk("R4", got, 32'h00030809);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R4", got, 32'h00030809);
    cyc(0, 0, 0, 1, 4'd0, got);
    chk("R4", got, 32'h00010009);
    cyc(0, 0, 0, 1, 4'd11, got);
    chk("R8", got, 32'h00000003);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule